// File: doc/BRIEF.md
# Serially Programmed Input Alignment Delays

This block sits in front of a pixel mixing pipeline and gives each of five signal groups its own delay of zero to seven clock cycles. The groups are pixel A, pixel B, the alpha word together with its load enable, the operand format bit, and the rounding code. With these delays, inputs that reach the chip at different pipeline depths can be lined up before they meet in the arithmetic.

The delay settings are held in a 15-bit control word of five 3-bit fields. The word is written one bit per strobe through a serial data pin and a load strobe. The strobe is asynchronous to the system clock. It is synchronized, and each rising edge it makes shifts one data bit into the word. The strobe never clocks the delay lines; only the system clock moves them. A bypass input forces every delay to zero and clears the control word.

Top module: `tap_align_top`

## Requirements
- R1: A synchronous active-high reset clears the control word and every delay stage, so after reset each output equals its input in the same cycle.
- R2: Field positions in the control word are: bits 2:0 pixel A, bits 5:3 pixel B, bits 8:6 alpha and its load enable, bits 11:9 format bit, bits 14:12 rounding code. Each field is an unsigned count of extra stages. For example, 3'b100 in bits 5:3 delays pixel B by four cycles.
- R3: Each rising edge of the load strobe shifts the control word right by one place and puts the sampled serial bit into bit 14. The first bit sent therefore ends in bit 0 after fifteen strobes. Three strobes carrying 1,0,0 leave the rounding field at 1. With no strobe edge, the word holds, whatever the serial data pin does.
- R4: With a field value n from 1 to 7, the group's output in a clock cycle equals that group's input from n cycles earlier.
- R5: With a field value of 0, the group's output follows its input within the same cycle, with no register in between.
- R6: While bypass is high, all outputs equal their inputs in the same cycle. Strobe edges are ignored, and the control word is cleared. After bypass falls, every delay stays zero until the word is loaded again.
- R7: The alpha load enable is delayed by the alpha field together with the alpha word, so each enable stays paired with the word it arrived with.
- R8: The strobe and serial data pass through the same synchronizer of SYNC_STAGES flops. The bit captured is the serial data level that was present with the strobe rising edge. Serial data must be held for SYNC_STAGES+1 cycles around that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; advances all delay lines |
| rst_i | input | 1 | Synchronous reset, active high |
| ser_dat_i | input | 1 | Serial control data bit |
| ser_stb_i | input | 1 | Asynchronous load strobe; rising edge shifts one bit |
| bypass_i | input | 1 | Forces all delays to zero and clears the control word |
| pix_a_i | input | PIX_W | Pixel A input |
| pix_b_i | input | PIX_W | Pixel B input |
| alpha_i | input | ALPHA_W | Alpha word input |
| alpha_ld_i | input | 1 | Alpha load enable input |
| fmt_i | input | 1 | Operand format bit input |
| rnd_i | input | RND_W | Rounding code input |
| pix_a_o | output | PIX_W | Delayed pixel A |
| pix_b_o | output | PIX_W | Delayed pixel B |
| alpha_o | output | ALPHA_W | Delayed alpha word |
| alpha_ld_o | output | 1 | Delayed alpha load enable |
| fmt_o | output | 1 | Delayed format bit |
| rnd_o | output | RND_W | Delayed rounding code |

## Verification
The bench loads eight control words that between them give every group every count from 0 to 7. Against each word it compares all outputs with a per-cycle input pattern computed arithmetically. A tap that is off by one, a zero setting that adds a register, or swapped fields would each show here as outputs that take values from the wrong cycle. A three-strobe partial load, and a word that sets only the pixel B field, separate a register that shifts the wrong way or lands bits reversed. Other cases toggle the serial data with no strobe, and pulse the strobe while bypass is high. A design that shifts on level instead of edge, or that keeps its old word through bypass, would leave nonzero delays where zero is expected.

// File: rtl/tap_align_pkg.sv
package tap_align_pkg;

    localparam int unsigned NUM_GRP = 5;

    typedef enum logic [2:0] {
        GRP_PIX_A = 3'd0,
        GRP_PIX_B = 3'd1,
        GRP_ALPHA = 3'd2,
        GRP_FMT   = 3'd3,
        GRP_RND   = 3'd4
    } grp_e;

endpackage

// File: rtl/tap_align_ctl.sv
module tap_align_ctl #(
    parameter int unsigned FIELD_W     = 3,
    parameter int unsigned NUM_FIELDS  = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic                            ser_dat_i,
    input  logic                            ser_stb_i,
    input  logic                            bypass_i,
    output logic [FIELD_W*NUM_FIELDS-1:0]   cfg_o
);
    localparam int unsigned CTL_W = FIELD_W * NUM_FIELDS;
    localparam int unsigned SMSB  = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] stb_sync;
        logic [SYNC_STAGES-1:0] dat_sync;
        logic                   stb_prev;
        logic [CTL_W-1:0]       word;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       stb_edge;

    // Strobe and data share one synchronizer depth so they stay aligned
    always_comb begin
        st_d          = st_q;
        st_d.stb_sync = {st_q.stb_sync[SYNC_STAGES-2:0], ser_stb_i};
        st_d.dat_sync = {st_q.dat_sync[SYNC_STAGES-2:0], ser_dat_i};
        st_d.stb_prev = st_q.stb_sync[SMSB];
        stb_edge      = st_q.stb_sync[SMSB] & ~st_q.stb_prev;
        if (bypass_i) begin
            st_d.word = '0;
        end else if (stb_edge) begin
            st_d.word = {st_q.dat_sync[SMSB], st_q.word[CTL_W-1:1]};
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o = bypass_i ? '0 : st_q.word;

    assert_bypass_clears_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        bypass_i |=> (st_q.word == '0));

    assert_hold_without_edge_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bypass_i && !stb_edge) |=> $stable(st_q.word));

    assert_shift_on_edge_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!bypass_i && stb_edge) |=> (st_q.word[CTL_W-2:0] == $past(st_q.word[CTL_W-1:1])));

    assert_edge_single_cycle_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        stb_edge |=> !stb_edge);

endmodule

// File: rtl/tap_align_line.sv
module tap_align_line #(
    parameter int unsigned WIDTH = 12,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    localparam int unsigned DEPTH = (1 << SEL_W) - 1;

    logic [WIDTH-1:0] stage_d [DEPTH];
    logic [WIDTH-1:0] stage_q [DEPTH];

    always_comb begin
        stage_d[0] = din_i;
        for (int k = 1; k < DEPTH; k++) begin
            stage_d[k] = stage_q[k-1];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int k = 0; k < DEPTH; k++) begin
                stage_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                stage_q[k] <= stage_d[k];
            end
        end
    end

    // Tap select: zero passes the input straight through
    always_comb begin
        dout_o = din_i;
        for (int k = 1; k <= DEPTH; k++) begin
            if (sel_i == SEL_W'(k)) begin
                dout_o = stage_q[k-1];
            end
        end
    end

    assert_tap_one_cycle_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i == SEL_W'(1) && !$past(rst_i)) |-> (dout_o == $past(din_i)));

    assert_tap_zero_through_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (sel_i == '0) |-> (dout_o == din_i));

endmodule

// File: rtl/tap_align_top.sv
module tap_align_top
    import tap_align_pkg::*;
#(
    parameter int unsigned PIX_W       = 12,
    parameter int unsigned ALPHA_W     = 12,
    parameter int unsigned RND_W       = 2,
    parameter int unsigned FIELD_W     = 3,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               ser_dat_i,
    input  logic               ser_stb_i,
    input  logic               bypass_i,
    input  logic [PIX_W-1:0]   pix_a_i,
    input  logic [PIX_W-1:0]   pix_b_i,
    input  logic [ALPHA_W-1:0] alpha_i,
    input  logic               alpha_ld_i,
    input  logic               fmt_i,
    input  logic [RND_W-1:0]   rnd_i,
    output logic [PIX_W-1:0]   pix_a_o,
    output logic [PIX_W-1:0]   pix_b_o,
    output logic [ALPHA_W-1:0] alpha_o,
    output logic               alpha_ld_o,
    output logic               fmt_o,
    output logic [RND_W-1:0]   rnd_o
);
    function automatic int grp_w(int g);
        case (g)
            int'(GRP_PIX_A): return int'(PIX_W);
            int'(GRP_PIX_B): return int'(PIX_W);
            int'(GRP_ALPHA): return int'(ALPHA_W) + 1;
            int'(GRP_FMT):   return 1;
            default:         return int'(RND_W);
        endcase
    endfunction

    function automatic int grp_off(int g);
        int acc = 0;
        for (int i = 0; i < g; i++) begin
            acc += grp_w(i);
        end
        return acc;
    endfunction

    localparam int unsigned BUS_W = grp_off(NUM_GRP);
    localparam int unsigned CTL_W = FIELD_W * NUM_GRP;

    logic [CTL_W-1:0] cfg;
    logic [BUS_W-1:0] bus_in;
    logic [BUS_W-1:0] bus_out;

    assign bus_in = {rnd_i, fmt_i, alpha_ld_i, alpha_i, pix_b_i, pix_a_i};
    assign {rnd_o, fmt_o, alpha_ld_o, alpha_o, pix_b_o, pix_a_o} = bus_out;

    tap_align_ctl #(
        .FIELD_W    (FIELD_W),
        .NUM_FIELDS (NUM_GRP),
        .SYNC_STAGES(SYNC_STAGES)
    ) i_ctl (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .ser_dat_i(ser_dat_i),
        .ser_stb_i(ser_stb_i),
        .bypass_i (bypass_i),
        .cfg_o    (cfg)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_line
        tap_align_line #(
            .WIDTH(grp_w(g)),
            .SEL_W(FIELD_W)
        ) i_line (
            .clk_i (clk_i),
            .rst_i (rst_i),
            .sel_i (cfg[g*FIELD_W +: FIELD_W]),
            .din_i (bus_in[grp_off(g) +: grp_w(g)]),
            .dout_o(bus_out[grp_off(g) +: grp_w(g)])
        );
    end

    assert_bypass_passthrough_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        bypass_i |-> (bus_out == bus_in));

endmodule

// File: tb/test_tap_align_top.sv
module test_tap_align_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ser_dat, ser_stb, bypass;
    logic [11:0] pix_a, pix_b, alpha;
    logic        alpha_ld, fmt;
    logic [1:0]  rnd;
    logic [11:0] pix_a_o, pix_b_o, alpha_o;
    logic        alpha_ld_o, fmt_o;
    logic [1:0]  rnd_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_dly [5];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tap_align_top i_tap_align_top (
        .clk_i(clk), .rst_i(rst), .ser_dat_i(ser_dat), .ser_stb_i(ser_stb),
        .bypass_i(bypass), .pix_a_i(pix_a), .pix_b_i(pix_b), .alpha_i(alpha),
        .alpha_ld_i(alpha_ld), .fmt_i(fmt), .rnd_i(rnd),
        .pix_a_o(pix_a_o), .pix_b_o(pix_b_o), .alpha_o(alpha_o),
        .alpha_ld_o(alpha_ld_o), .fmt_o(fmt_o), .rnd_o(rnd_o)
    );

    function automatic logic [31:0] pat(int g, int t);
        logic [31:0] x;
        x = 32'(t) * 32'h9E3779B1 + 32'(g) * 32'h7F4A7C15;
        return x ^ (x >> 13);
    endfunction

    task automatic drive_cycle();
        logic [31:0] v;
        v = pat(0, cyc); pix_a = v[11:0];
        v = pat(1, cyc); pix_b = v[11:0];
        v = pat(2, cyc); alpha = v[11:0]; alpha_ld = v[12];
        v = pat(3, cyc); fmt = v[0];
        v = pat(4, cyc); rnd = v[1:0];
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        drive_cycle();
        #1;
    endtask

    task automatic cmp(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    // Compare all outputs with the pattern from exp_dly cycles ago
    task automatic check_all(string req);
        logic [31:0] e;
        string r;
        e = pat(0, cyc - exp_dly[0]);
        r = (exp_dly[0] == 0) ? "R5" : req;
        cmp(r, "pix_a", 32'(pix_a_o), 32'(e[11:0]));
        e = pat(1, cyc - exp_dly[1]);
        r = (exp_dly[1] == 0) ? "R5" : req;
        cmp(r, "pix_b", 32'(pix_b_o), 32'(e[11:0]));
        e = pat(2, cyc - exp_dly[2]);
        r = (exp_dly[2] == 0) ? "R5" : req;
        cmp(r, "alpha", 32'(alpha_o), 32'(e[11:0]));
        cmp("R7", "alpha_ld", 32'(alpha_ld_o), 32'(e[12]));
        e = pat(3, cyc - exp_dly[3]);
        r = (exp_dly[3] == 0) ? "R5" : req;
        cmp(r, "fmt", 32'(fmt_o), 32'(e[0]));
        e = pat(4, cyc - exp_dly[4]);
        r = (exp_dly[4] == 0) ? "R5" : req;
        cmp(r, "rnd", 32'(rnd_o), 32'(e[1:0]));
    endtask

    task automatic set_dly(logic [14:0] w);
        for (int g = 0; g < 5; g++) exp_dly[g] = int'(w[g*3 +: 3]);
    endtask

    // Send nbits of w, bit 0 first; data held across the synchronized edge (R8)
    task automatic send_bits(logic [14:0] w, int nbits);
        for (int i = 0; i < nbits; i++) begin
            ser_dat = w[i];
            tick();
            ser_stb = 1'b1;
            repeat (4) tick();
            ser_stb = 1'b0;
            repeat (3) tick();
        end
    endtask

    task automatic run_checks(string req, int n);
        for (int i = 0; i < n; i++) begin
            tick();
            check_all(req);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 60000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [14:0] w;
        rst = 1'b1; ser_dat = 1'b0; ser_stb = 1'b0; bypass = 1'b0;
        drive_cycle();
        repeat (5) tick();
        rst = 1'b0;

        // R1: zero delays after reset
        set_dly(15'h0);
        run_checks("R1", 6);

        // R3: three strobes carrying 1,0,0 set the rounding field to 1
        send_bits(15'b000_0000_0000_0001, 3);
        set_dly(15'b001_000_000_000_000);
        run_checks("R3", 6);

        // R2: only the pixel B field set to 4
        w = 15'b000_000_000_100_000;
        send_bits(w, 15);
        set_dly(w);
        run_checks("R2", 8);

        // R4: sweep; each group sees every count 0..7
        for (int k = 0; k < 8; k++) begin
            w = '0;
            for (int g = 0; g < 5; g++) w[g*3 +: 3] = 3'((k + g) % 8);
            send_bits(w, 15);
            set_dly(w);
            run_checks("R4", 12);
        end

        // R3: serial data toggling without strobe leaves the word alone
        for (int i = 0; i < 12; i++) begin
            tick();
            ser_dat = ~ser_dat;
            check_all("R3");
        end
        ser_dat = 1'b0;

        // R6: bypass forces zero delays, ignores strobes, clears the word
        w = 15'h7FFF;
        send_bits(w, 15);
        set_dly(w);
        run_checks("R4", 4);
        tick();
        bypass = 1'b1;
        #1;
        set_dly(15'h0);
        check_all("R6");
        ser_dat = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick(); check_all("R6");
            ser_stb = 1'b1;
            repeat (4) begin tick(); check_all("R6"); end
            ser_stb = 1'b0;
            repeat (3) begin tick(); check_all("R6"); end
        end
        ser_dat = 1'b0;
        repeat (4) tick();
        bypass = 1'b0;
        run_checks("R6", 10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule